// File: doc/BRIEF.md
# Receive Descriptor Status Writeback Engine

This block takes a byte-by-byte receive frame stream and places it into a ring of chained receive descriptors. Each descriptor offers two buffers. The engine counts how much room the current descriptor has left and moves to the next descriptor when that room runs out. Each time it finishes with a descriptor it emits a 32-bit status word. The word hands the descriptor back to software and marks whether it holds the start or the end of a frame. It also carries the frame's running byte count and, in the closing descriptor, the error flags collected over the frame.

The engine reads descriptors lazily. It looks at the current descriptor's ownership and buffer sizes only when a byte is waiting. While software still owns that descriptor, the engine holds the stream and raises an unavailable indication. When a frame outgrows a descriptor and the following descriptor is not yet handed over, the frame is cut short with a descriptor error. The rest of that frame is then consumed and discarded. A receive watchdog input cuts a frame short in the same way.

The index of the descriptor being closed travels with each status word. The index wraps at a configurable ring size.

Top module: `rxDescStatusEngine`

## Requirements
- R1: After reset, no status is written, the descriptor index is 0 and the unavailable indication is low.
- R2: A frame that fits in one descriptor produces one status word. Bit 31 (ownership) is 0, bit 9 (first) is 1 and bit 8 (last) is 1. Bits 29:16 hold the number of accepted bytes, CRC bytes included. Every other bit is 0.
- R3: A frame longer than buf1+buf2 of a descriptor closes that descriptor when its last byte slot fills. It is closed with bit 8 clear and bits 29:16 holding the bytes accepted so far for the frame. Bit 9 is set only on the descriptor that took the frame's first byte.
- R4: When buffer 1 has size 0, the capacity of the descriptor is the size of buffer 2. A descriptor with both sizes 0 is written back with bits 9 and 8 clear and bits 29:16 equal to the bytes accepted so far. The first marker then falls in the next descriptor.
- R5: If a descriptor fills before the frame ends while the next descriptor is not engine-owned, that descriptor is closed with bit 14 (descriptor error), bit 15 and bit 8 set. The rest of the frame is accepted and discarded. The next frame starts in the next descriptor with a fresh count.
- R6: These end-of-frame error inputs are sampled with the final byte: CRC error (bit 1), late collision (bit 6), giant frame (bit 7) and overflow (bit 11). They appear only in a descriptor with bit 8 set.
- R7: Bit 3 is set in the closing descriptor if the receive error input was high on any accepted byte of the frame.
- R8: Bit 15 is the OR of bits 1, 3, 4, 6, 7, 11 and 14. It is 0 in every descriptor without bit 8.
- R9: A byte accepted with the watchdog input high ends the frame at that byte. The descriptor is closed with bits 8, 4 and 15 set. The remaining bytes of the frame are discarded.
- R10: While a byte is waiting and the current descriptor is not engine-owned, the unavailable output is high, the ready output is low, and no status is written.
- R11: The write strobe is high for one cycle, in the cycle after the closing byte is accepted, together with the closed descriptor's index. The index after RING_SIZE-1 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | A frame byte is offered |
| inLast | input | 1 | Offered byte is the frame's final byte |
| inRxErr | input | 1 | Line receive error on this byte |
| inCrcErr | input | 1 | CRC check failed (with final byte) |
| inLateCol | input | 1 | Late collision (with final byte) |
| inGiant | input | 1 | Frame exceeded the size limit (with final byte) |
| inOverflow | input | 1 | Receive FIFO overflowed (with final byte) |
| inWdog | input | 1 | Receive watchdog expired at this byte |
| inReady | output | 1 | Byte is taken on this edge when inValid is high |
| descBuf1Size | input | BUF_W | Buffer 1 size of the current descriptor |
| descBuf2Size | input | BUF_W | Buffer 2 size of the current descriptor |
| descOwn | input | 1 | Current descriptor is engine-owned |
| nextOwn | input | 1 | Following descriptor is engine-owned |
| descIndex | output | IDX_W | Index of the current descriptor |
| descUnavail | output | 1 | Stalled on a software-owned descriptor |
| wbValid | output | 1 | Status write strobe |
| wbStatus | output | 32 | Status word being written |
| wbIndex | output | IDX_W | Index of the descriptor being closed |

## Verification
Frames shorter than one descriptor are compared with frames spanning two descriptors. This separates a fresh per-descriptor count from a count that keeps running across descriptors, and shows that first and last markers land on different words. Descriptors with an empty buffer 1, or with both buffers empty, check that capacity comes from the sizes and that the first marker moves forward. Truncation by a host-owned next descriptor and by the watchdog is followed by a clean frame, which shows that discarded bytes leave no trace in the count. A frame across single-byte descriptors drives the index through the ring wrap, and a stall on an unowned descriptor shows that nothing is consumed while unavailable is high.

// File: rtl/rxdsw_pkg.sv
package rxdsw_pkg;

  // Width of the byte-count field in the status word
  localparam int FL_W = 14;

  // Status word bit positions
  localparam int B_OWN   = 31;
  localparam int FL_LO   = 16;
  localparam int B_ES    = 15;
  localparam int B_DE    = 14;
  localparam int B_OVF   = 11;
  localparam int B_FS    = 9;
  localparam int B_LD    = 8;
  localparam int B_GIANT = 7;
  localparam int B_LATE  = 6;
  localparam int B_WDOG  = 4;
  localparam int B_RXERR = 3;
  localparam int B_CRC   = 1;

  typedef enum logic [1:0] {
    ST_OPEN = 2'd0,
    ST_FILL = 2'd1,
    ST_DROP = 2'd2
  } fillState_t;

  typedef struct packed {
    logic open;
    logic accept;
    logic closeLast;
    logic closeFull;
    logic closeTrunc;
    logic closeSkip;
  } ctrlStrobes_t;

endpackage

// File: rtl/rxdswCtrl.sv
module rxdswCtrl
  import rxdsw_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  input  logic         inLast,
  input  logic         inWdog,
  input  logic         descOwn,
  input  logic         nextOwn,
  input  logic         capZero,
  input  logic         lastSlot,
  output logic         inReady,
  output logic         descUnavail,
  output ctrlStrobes_t strobe
);

  fillState_t state, stateNext;

  always_comb begin
    stateNext   = state;
    inReady     = 1'b0;
    descUnavail = 1'b0;
    strobe      = '0;
    unique case (state)
      ST_OPEN: begin
        // a descriptor is looked at only when a byte is waiting
        if (inValid) begin
          if (!descOwn) begin
            descUnavail = 1'b1;
          end else if (capZero) begin
            strobe.closeSkip = 1'b1;
          end else begin
            strobe.open = 1'b1;
            stateNext   = ST_FILL;
          end
        end
      end
      ST_FILL: begin
        inReady = 1'b1;
        if (inValid) begin
          strobe.accept = 1'b1;
          if (inLast || inWdog) begin
            strobe.closeLast = 1'b1;
            stateNext = inLast ? ST_OPEN : ST_DROP;
          end else if (lastSlot) begin
            if (nextOwn) begin
              strobe.closeFull = 1'b1;
              stateNext = ST_OPEN;
            end else begin
              strobe.closeTrunc = 1'b1;
              stateNext = ST_DROP;
            end
          end
        end
      end
      ST_DROP: begin
        inReady = 1'b1;
        if (inValid && inLast) stateNext = ST_OPEN;
      end
      default: stateNext = ST_OPEN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_OPEN;
    else       state <= stateNext;
  end

endmodule

// File: rtl/rxdswData.sv
module rxdswData
  import rxdsw_pkg::*;
#(
  parameter int RING_SIZE = 8,
  parameter int BUF_W     = 13,
  parameter int IDX_W     = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobes_t       strobe,
  input  logic               inLast,
  input  logic               inRxErr,
  input  logic               inCrcErr,
  input  logic               inLateCol,
  input  logic               inGiant,
  input  logic               inOverflow,
  input  logic               inWdog,
  input  logic [BUF_W-1:0]   descBuf1Size,
  input  logic [BUF_W-1:0]   descBuf2Size,
  output logic               capZero,
  output logic               lastSlot,
  output logic [IDX_W-1:0]   descIndex,
  output logic               wbValid,
  output logic [31:0]        wbStatus,
  output logic [IDX_W-1:0]   wbIndex
);

  localparam int FLW   = FL_W;
  localparam int SUM_W = BUF_W + 1;

  logic [FLW-1:0]   remaining;
  logic [FLW-1:0]   frameCount;
  logic             descHasFirst;
  logic             rxErrSeen;
  logic [IDX_W-1:0] idxReg;

  logic             closing;
  logic             frameEnd;
  logic [SUM_W-1:0] capSum;
  logic [FLW-1:0]   capacity;
  logic [IDX_W-1:0] idxNext;
  logic [FLW-1:0]   lenNow;
  logic             firstNow;
  logic             errCrc, errLate, errGiant, errOvf, errRx, errWd, errDe, errSum;
  logic [31:0]      statusNext;

  assign closing  = strobe.closeLast | strobe.closeFull | strobe.closeTrunc | strobe.closeSkip;
  assign frameEnd = strobe.closeLast | strobe.closeTrunc;

  assign capSum   = SUM_W'(descBuf1Size) + SUM_W'(descBuf2Size);
  assign capacity = FLW'(capSum);
  assign capZero  = (capSum == '0);
  assign lastSlot = (remaining == FLW'(1));

  assign idxNext  = (idxReg == IDX_W'(RING_SIZE - 1)) ? '0 : idxReg + 1'b1;
  assign descIndex = idxReg;

  // status word assembly
  always_comb begin
    lenNow   = strobe.accept ? frameCount + 1'b1 : frameCount;
    firstNow = descHasFirst | (strobe.accept && (frameCount == '0));
    errCrc   = strobe.closeLast & inLast & inCrcErr;
    errLate  = strobe.closeLast & inLast & inLateCol;
    errGiant = strobe.closeLast & inLast & inGiant;
    errOvf   = strobe.closeLast & inLast & inOverflow;
    errWd    = strobe.closeLast & inWdog;
    errRx    = frameEnd & (rxErrSeen | inRxErr);
    errDe    = strobe.closeTrunc;
    errSum   = errCrc | errLate | errGiant | errOvf | errWd | errRx | errDe;

    statusNext                      = '0;
    statusNext[B_OWN]               = 1'b0;
    statusNext[FL_LO +: FLW]        = lenNow;
    statusNext[B_ES]                = errSum;
    statusNext[B_DE]                = errDe;
    statusNext[B_OVF]               = errOvf;
    statusNext[B_FS]                = firstNow & ~strobe.closeSkip;
    statusNext[B_LD]                = frameEnd;
    statusNext[B_GIANT]             = errGiant;
    statusNext[B_LATE]              = errLate;
    statusNext[B_WDOG]              = errWd;
    statusNext[B_RXERR]             = errRx;
    statusNext[B_CRC]               = errCrc;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remaining    <= '0;
      frameCount   <= '0;
      descHasFirst <= 1'b0;
      rxErrSeen    <= 1'b0;
      idxReg       <= '0;
    end else begin
      if (strobe.open)        remaining <= capacity;
      else if (strobe.accept) remaining <= remaining - 1'b1;

      if (strobe.accept) begin
        frameCount <= frameEnd ? '0 : frameCount + 1'b1;
        rxErrSeen  <= frameEnd ? 1'b0 : (rxErrSeen | inRxErr);
      end

      if (closing)                                    descHasFirst <= 1'b0;
      else if (strobe.accept && (frameCount == '0))   descHasFirst <= 1'b1;

      if (closing) idxReg <= idxNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wbValid  <= 1'b0;
      wbStatus <= '0;
      wbIndex  <= '0;
    end else begin
      wbValid <= closing;
      if (closing) begin
        wbStatus <= statusNext;
        wbIndex  <= idxReg;
      end
    end
  end

endmodule

// File: rtl/rxDescStatusEngine.sv
module rxDescStatusEngine
  import rxdsw_pkg::*;
#(
  parameter  int RING_SIZE = 8,
  parameter  int BUF_W     = 13,
  localparam int IDX_W     = (RING_SIZE > 1) ? $clog2(RING_SIZE) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             inLast,
  input  logic             inRxErr,
  input  logic             inCrcErr,
  input  logic             inLateCol,
  input  logic             inGiant,
  input  logic             inOverflow,
  input  logic             inWdog,
  output logic             inReady,
  input  logic [BUF_W-1:0] descBuf1Size,
  input  logic [BUF_W-1:0] descBuf2Size,
  input  logic             descOwn,
  input  logic             nextOwn,
  output logic [IDX_W-1:0] descIndex,
  output logic             descUnavail,
  output logic             wbValid,
  output logic [31:0]      wbStatus,
  output logic [IDX_W-1:0] wbIndex
);

  initial begin
    if (BUF_W + 1 > FL_W) $error("BUF_W too wide for the byte-count field");
    if (RING_SIZE < 2)    $error("RING_SIZE must be at least 2");
  end

  ctrlStrobes_t strobe;
  logic         capZero;
  logic         lastSlot;

  rxdswCtrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .inValid    (inValid),
    .inLast     (inLast),
    .inWdog     (inWdog),
    .descOwn    (descOwn),
    .nextOwn    (nextOwn),
    .capZero    (capZero),
    .lastSlot   (lastSlot),
    .inReady    (inReady),
    .descUnavail(descUnavail),
    .strobe     (strobe)
  );

  rxdswData #(
    .RING_SIZE(RING_SIZE),
    .BUF_W    (BUF_W),
    .IDX_W    (IDX_W)
  ) uData (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .inLast      (inLast),
    .inRxErr     (inRxErr),
    .inCrcErr    (inCrcErr),
    .inLateCol   (inLateCol),
    .inGiant     (inGiant),
    .inOverflow  (inOverflow),
    .inWdog      (inWdog),
    .descBuf1Size(descBuf1Size),
    .descBuf2Size(descBuf2Size),
    .capZero     (capZero),
    .lastSlot    (lastSlot),
    .descIndex   (descIndex),
    .wbValid     (wbValid),
    .wbStatus    (wbStatus),
    .wbIndex     (wbIndex)
  );

endmodule

// File: rtl/rxDescStatusEngine_chk.sv
module rxDescStatusEngine_chk #(
  parameter int RING_SIZE = 8,
  parameter int IDX_W     = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic             inReady,
  input logic             descUnavail,
  input logic [IDX_W-1:0] descIndex,
  input logic             wbValid,
  input logic [31:0]      wbStatus,
  input logic [IDX_W-1:0] wbIndex
);

  logic [IDX_W-1:0] idxAfterWb;
  assign idxAfterWb = (wbIndex == IDX_W'(RING_SIZE - 1)) ? '0 : wbIndex + 1'b1;

  // R10
  unavail_blocks_chk: assert property (@(posedge clk) disable iff (!rstN)
    descUnavail |-> (!inReady && !wbValid));

  // R5
  trunc_is_last_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wbValid && wbStatus[14]) |-> (wbStatus[8] && wbStatus[15]));

  // R8
  summary_only_last_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wbValid && !wbStatus[8]) |-> !wbStatus[15]);

  // R11
  index_advanced_chk: assert property (@(posedge clk) disable iff (!rstN)
    wbValid |-> (descIndex == idxAfterWb));

  // R2
  first_has_bytes_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wbValid && wbStatus[9]) |-> (wbStatus[29:16] != 14'd0));

  // R2
  owner_released_chk: assert property (@(posedge clk) disable iff (!rstN)
    wbValid |-> !wbStatus[31]);

endmodule

bind rxDescStatusEngine rxDescStatusEngine_chk #(
  .RING_SIZE(RING_SIZE),
  .IDX_W    (IDX_W)
) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .inValid    (inValid),
  .inReady    (inReady),
  .descUnavail(descUnavail),
  .descIndex  (descIndex),
  .wbValid    (wbValid),
  .wbStatus   (wbStatus),
  .wbIndex    (wbIndex)
);

// File: tb/tb_rxDescStatusEngine.sv
`timescale 1ns/1ps
module tb_rxDescStatusEngine;

  localparam int RING  = 8;
  localparam int BUF_W = 13;
  localparam int IDX_W = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0, inLast = 1'b0, inRxErr = 1'b0, inCrcErr = 1'b0;
  logic inLateCol = 1'b0, inGiant = 1'b0, inOverflow = 1'b0, inWdog = 1'b0;
  logic inReady;
  logic [BUF_W-1:0] descBuf1Size, descBuf2Size;
  logic descOwn, nextOwn;
  logic [IDX_W-1:0] descIndex;
  logic descUnavail;
  logic wbValid;
  logic [31:0] wbStatus;
  logic [IDX_W-1:0] wbIndex;

  logic             ringOwn [RING];
  logic [BUF_W-1:0] ringB1  [RING];
  logic [BUF_W-1:0] ringB2  [RING];

  assign descOwn      = ringOwn[descIndex];
  assign nextOwn      = ringOwn[(int'(descIndex) + 1) % RING];
  assign descBuf1Size = ringB1[descIndex];
  assign descBuf2Size = ringB2[descIndex];

  always #2.5 clk = ~clk;

  rxDescStatusEngine #(.RING_SIZE(RING), .BUF_W(BUF_W)) dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inLast(inLast), .inRxErr(inRxErr),
    .inCrcErr(inCrcErr), .inLateCol(inLateCol), .inGiant(inGiant),
    .inOverflow(inOverflow), .inWdog(inWdog), .inReady(inReady),
    .descBuf1Size(descBuf1Size), .descBuf2Size(descBuf2Size),
    .descOwn(descOwn), .nextOwn(nextOwn), .descIndex(descIndex),
    .descUnavail(descUnavail), .wbValid(wbValid), .wbStatus(wbStatus),
    .wbIndex(wbIndex)
  );

  int compared = 0;
  int mismatched = 0;
  int expIdx = 0;

  logic [31:0]      capStatus [256];
  logic [IDX_W-1:0] capIdx    [256];
  int capN = 0;

  always @(negedge clk) begin
    if (rstN && wbValid && capN < 256) begin
      capStatus[capN] = wbStatus;
      capIdx[capN]    = wbIndex;
      capN++;
    end
  end

  task automatic check32(string req, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic restoreRing();
    for (int i = 0; i < RING; i++) begin
      ringOwn[i] = 1'b1;
      ringB1[i]  = BUF_W'(4);
      ringB2[i]  = BUF_W'(4);
    end
  endtask

  // returns at the negedge after the byte was accepted
  task automatic sendByte(bit last, bit rxErr, bit wd, bit crc, bit late, bit giant, bit ovf);
    inValid = 1'b1; inLast = last; inRxErr = rxErr; inWdog = wd;
    inCrcErr = crc; inLateCol = late; inGiant = giant; inOverflow = ovf;
    while (!inReady) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic idleInputs();
    inValid = 1'b0; inLast = 1'b0; inRxErr = 1'b0; inWdog = 1'b0;
    inCrcErr = 1'b0; inLateCol = 1'b0; inGiant = 1'b0; inOverflow = 1'b0;
  endtask

  task automatic sendFrame(int n, int rxErrAt, int wdogAt, bit crc, bit late, bit giant, bit ovf);
    @(negedge clk);
    for (int i = 0; i < n; i++) begin
      if (i == n - 1) sendByte(1'b1, i == rxErrAt, i == wdogAt, crc, late, giant, ovf);
      else            sendByte(1'b0, i == rxErrAt, i == wdogAt, 1'b0, 1'b0, 1'b0, 1'b0);
    end
    idleInputs();
    repeat (2) @(negedge clk);
  endtask

  task automatic expectWb(string req, int base, int k, logic [31:0] st);
    check32({req, " status"}, capStatus[base + k], st);
    check32({req, " index"}, 32'(capIdx[base + k]), 32'(expIdx));
    expIdx = (expIdx + 1) % RING;
  endtask

  task automatic expectCount(string req, int base, int n);
    check32({req, " writeback count"}, 32'(capN - base), 32'(n));
  endtask

  task automatic testReset();
    // R1
    check32("R1 wbValid", 32'(wbValid), 32'd0);
    check32("R1 descIndex", 32'(descIndex), 32'd0);
    check32("R1 descUnavail", 32'(descUnavail), 32'd0);
  endtask

  task automatic testSingle();
    int base = capN;
    restoreRing();
    sendFrame(5, -1, -1, 0, 0, 0, 0);
    expectCount("R2", base, 1);
    expectWb("R2", base, 0, 32'h0005_0300);
  endtask

  task automatic testSpan();
    int base = capN;
    restoreRing();
    // R3 with R7: error seen in the first descriptor reported only at the end
    sendFrame(10, 1, -1, 0, 0, 0, 0);
    expectCount("R3", base, 2);
    expectWb("R3 first part", base, 0, 32'h0008_0200);
    expectWb("R7 closing part", base, 1, 32'h000A_8108);
  endtask

  task automatic testZeroBuf1();
    int base = capN;
    restoreRing();
    ringB1[expIdx] = '0;
    ringB2[expIdx] = BUF_W'(3);
    sendFrame(4, -1, -1, 0, 0, 0, 0);
    expectCount("R4 buf1 zero", base, 2);
    expectWb("R4 buf1 zero", base, 0, 32'h0003_0200);
    expectWb("R4 buf1 zero tail", base, 1, 32'h0004_0100);
  endtask

  task automatic testBothZero();
    int base = capN;
    restoreRing();
    ringB1[expIdx] = '0;
    ringB2[expIdx] = '0;
    sendFrame(2, -1, -1, 0, 0, 0, 0);
    expectCount("R4 both zero", base, 2);
    expectWb("R4 skipped", base, 0, 32'h0000_0000);
    expectWb("R4 first moved", base, 1, 32'h0002_0300);
  endtask

  task automatic testDescError();
    int base = capN;
    restoreRing();
    ringB1[expIdx] = BUF_W'(2);
    ringB2[expIdx] = BUF_W'(2);
    ringOwn[(expIdx + 1) % RING] = 1'b0;
    sendFrame(6, -1, -1, 0, 0, 0, 0);
    expectCount("R5 truncation", base, 1);
    expectWb("R5 truncation", base, 0, 32'h0004_C300);
    restoreRing();
    base = capN;
    sendFrame(3, -1, -1, 0, 0, 0, 0);
    expectCount("R5 after drop", base, 1);
    expectWb("R5 after drop", base, 0, 32'h0003_0300);
  endtask

  task automatic testErrors();
    int base = capN;
    restoreRing();
    sendFrame(3, 0, -1, 1, 0, 0, 0);
    expectCount("R6 crc", base, 1);
    expectWb("R6 crc R7 rxerr R8", base, 0, 32'h0003_830A);
    base = capN;
    sendFrame(2, -1, -1, 0, 1, 1, 1);
    expectCount("R6 late giant ovf", base, 1);
    expectWb("R6 late giant ovf R8", base, 0, 32'h0002_8BC0);
  endtask

  task automatic testWatchdog();
    int base = capN;
    restoreRing();
    sendFrame(8, -1, 2, 0, 0, 0, 0);
    expectCount("R9 watchdog", base, 1);
    expectWb("R9 watchdog", base, 0, 32'h0003_8310);
    base = capN;
    sendFrame(1, -1, -1, 0, 0, 0, 0);
    expectCount("R9 next frame", base, 1);
    expectWb("R9 next frame", base, 0, 32'h0001_0300);
  endtask

  task automatic testUnavail();
    int base = capN;
    int idxBefore;
    restoreRing();
    ringOwn[expIdx] = 1'b0;
    idxBefore = int'(descIndex);
    @(negedge clk);
    inValid = 1'b1; inLast = 1'b0;
    repeat (3) @(negedge clk);
    check32("R10 descUnavail", 32'(descUnavail), 32'd1);
    check32("R10 inReady", 32'(inReady), 32'd0);
    check32("R10 no writeback", 32'(capN - base), 32'd0);
    check32("R10 index held", 32'(descIndex), 32'(idxBefore));
    ringOwn[expIdx] = 1'b1;
    sendByte(1'b0, 0, 0, 0, 0, 0, 0);
    sendByte(1'b1, 0, 0, 0, 0, 0, 0);
    idleInputs();
    repeat (2) @(negedge clk);
    expectCount("R10 resumed", base, 1);
    expectWb("R10 resumed", base, 0, 32'h0002_0300);
  endtask

  task automatic testWrap();
    int base = capN;
    restoreRing();
    for (int i = 0; i < RING; i++) begin
      ringB1[i] = BUF_W'(1);
      ringB2[i] = '0;
    end
    // R11: nine single-byte descriptors pass the end of the ring
    sendFrame(9, -1, -1, 0, 0, 0, 0);
    expectCount("R11 wrap", base, 9);
    for (int k = 0; k < 8; k++)
      expectWb("R11 wrap", base, k, (32'(k + 1) << 16) | (k == 0 ? 32'h200 : 32'h0));
    expectWb("R11 wrap end", base, 8, 32'h0009_0100);
  endtask

  task automatic testStrobeWidth();
    int hits = 0;
    restoreRing();
    @(negedge clk);
    inValid = 1'b1; inLast = 1'b1;
    while (!inReady) @(negedge clk);
    @(negedge clk);
    idleInputs();
    // R11: strobe present exactly in the cycle after acceptance, then low
    if (wbValid) hits++;
    @(negedge clk);
    if (wbValid) hits++;
    check32("R11 one-cycle strobe", 32'(hits), 32'd1);
    expIdx = (expIdx + 1) % RING;
  endtask

  initial begin
    restoreRing();
    idleInputs();
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    testReset();
    testSingle();
    testSpan();
    testZeroBuf1();
    testBothZero();
    testDescError();
    testErrors();
    testWatchdog();
    testUnavail();
    testWrap();
    testStrobeWidth();
    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL R11 watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule